// File: doc/BRIEF.md
# Scratch-Register Presence Prober

This block is a small bus master that works out which of four fixed serial-port address windows has a live scratch register behind it. A single start pulse launches one survey. For each window the block writes a known byte to the register seven bytes above the window base, reads that same address back, and calls the window occupied only if the returned byte matches the written one. It builds a four-bit occupancy map and a running total of occupied windows, and reports both when it finishes.

The block talks to a plain synchronous I/O bus. Each access holds a write or read strobe until the target raises a ready handshake. A target that never answers is caught by a per-access timeout and treated as absent, so a missing device cannot hang the survey. It is meant to run once at boot, before any driver touches the serial ports, and to leave its result on its outputs until the next survey starts.

Top module: `scratch_probe`

## Requirements
- R1: Windows are surveyed strictly in the order 0x3F8, 0x2F8, 0x3E8, 0x2E8, and bit i of `present_map` (bit 0 first) belongs to the i-th window of that order.
- R2: For each window the block first writes the byte 0x55 to base+7, and after that write completes it reads base+7 in the very next cycle.
- R3: A window is marked present only when its read completes with `io_rdata` equal to 0x55; any other returned byte leaves its map bit at 0.
- R4: `present_cnt` starts from zero on each survey, rises by one for each window marked present, and always equals the number of ones in `present_map`.
- R5: A strobe stays asserted, with address and data held, until `io_ready` is seen high. After TIMEOUT_CYC strobe cycles with no ready the access is abandoned and the window counts as absent; a write that times out is not followed by a read.
- R6: `done` is high for exactly one cycle after the last window is settled; from then on `present_cnt` and `present_map` hold until a new survey is accepted.
- R7: A `start` pulse while `busy` is high is ignored: the running survey neither restarts nor repeats any access.
- R8: Driving `rst_n` low clears the state, count and map at once and removes both strobes; `busy` and `done` are 0 during and after reset.
- R9: At most one of `io_wr` and `io_rd` is high in any cycle, and neither is high while `busy` is low.
- R10: A `start` accepted while idle clears count and map, and the write to the first window is on the bus in the following cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously upstream |
| start | input | 1 | Survey request, sampled when idle |
| busy | output | 1 | High from the accepted start up to and including the done cycle |
| done | output | 1 | One-cycle end-of-survey pulse |
| present_cnt | output | 3 | Number of windows found occupied |
| present_map | output | 4 | Per-window occupancy, bit i for the i-th window in order |
| io_addr | output | ADDR_W (16) | Bus address of the current access |
| io_wdata | output | DATA_W (8) | Write data, the test byte |
| io_wr | output | 1 | Write strobe, held until ready or timeout |
| io_rd | output | 1 | Read strobe, held until ready or timeout |
| io_rdata | input | DATA_W (8) | Read data, taken in the cycle ready is high |
| io_ready | input | 1 | Target handshake closing the current access |

## Verification
The bench builds the block with TIMEOUT_CYC set to 8 instead of the default 16, which keeps timed-out surveys short. With that value a bus model whose reply latency is 7 cycles answers in the final cycle of the window and must still be accepted, while a latency of 8 misses it on every access, so both edges of the timeout are hit directly. Bus address width, data width, register offset and test byte stay at their defaults, so the expected address sequence is the fixed legacy one.

// File: rtl/scratch_probe_pkg.sv
package scratch_probe_pkg;

  localparam int unsigned NUM_SLOTS = 4;
  localparam int unsigned SLOT_W    = $clog2(NUM_SLOTS);
  localparam int unsigned CNT_W     = $clog2(NUM_SLOTS + 1);

  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_WRITE = 2'd1,
    ST_READ  = 2'd2,
    ST_FIN   = 2'd3
  } probe_state_e;

  // Legacy window bases in survey order; the order sets the map bit order.
  function automatic logic [15:0] legacy_base(input int unsigned idx);
    logic [15:0] base;
    case (idx)
      0:       base = 16'h03F8;
      1:       base = 16'h02F8;
      2:       base = 16'h03E8;
      default: base = 16'h02E8;
    endcase
    return base;
  endfunction

endpackage

// File: rtl/probe_slot_map.sv
module probe_slot_map
  import scratch_probe_pkg::*;
#(
  parameter int unsigned ADDR_W  = 16,
  parameter int unsigned REG_OFF = 7
) (
  input  logic [SLOT_W-1:0] slot_idx,
  output logic [ADDR_W-1:0] reg_addr
);

  logic [ADDR_W-1:0] addr_tab [NUM_SLOTS];

  for (genvar g = 0; g < NUM_SLOTS; g++) begin : g_tab
    assign addr_tab[g] = ADDR_W'(32'(legacy_base(int'(g))) + REG_OFF);
  end

  assign reg_addr = addr_tab[slot_idx];

endmodule

// File: rtl/probe_access_timer.sv
module probe_access_timer #(
  parameter int unsigned TIMEOUT_CYC = 16
) (
  input  logic clk,
  input  logic rst_n,
  input  logic active,
  input  logic ready,
  output logic expired
);

  localparam int unsigned TW = (TIMEOUT_CYC > 1) ? $clog2(TIMEOUT_CYC) : 1;
  localparam logic [TW-1:0] LAST_WAIT = TW'(TIMEOUT_CYC - 1);

  logic [TW-1:0] wait_q, wait_d;
  logic          wait_en;

  assign expired = active && !ready && (wait_q == LAST_WAIT);

  always_comb begin
    wait_en = 1'b0;
    wait_d  = wait_q;
    if (!active || ready || expired) begin
      wait_en = (wait_q != '0);
      wait_d  = '0;
    end else begin
      wait_en = 1'b1;
      wait_d  = wait_q + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wait_q <= '0;
    end else if (wait_en) begin
      wait_q <= wait_d;
    end
  end

endmodule

// File: rtl/probe_tally.sv
module probe_tally
  import scratch_probe_pkg::*;
(
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 clear,
  input  logic                 hit_en,
  input  logic [SLOT_W-1:0]    hit_slot,
  output logic [CNT_W-1:0]     found_cnt,
  output logic [NUM_SLOTS-1:0] found_map
);

  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic             cnt_en;

  always_comb begin
    cnt_en = clear || hit_en;
    cnt_d  = clear ? '0 : cnt_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
    end else if (cnt_en) begin
      cnt_q <= cnt_d;
    end
  end

  for (genvar g = 0; g < NUM_SLOTS; g++) begin : g_bit
    logic bit_q;
    logic bit_en;
    assign bit_en = clear || (hit_en && (hit_slot == SLOT_W'(g)));
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        bit_q <= 1'b0;
      end else if (bit_en) begin
        bit_q <= !clear;
      end
    end
    assign found_map[g] = bit_q;
  end

  assign found_cnt = cnt_q;

endmodule

// File: rtl/scratch_probe.sv
module scratch_probe
  import scratch_probe_pkg::*;
#(
  parameter int unsigned       ADDR_W      = 16,
  parameter int unsigned       DATA_W      = 8,
  parameter int unsigned       REG_OFF     = 7,
  parameter logic [DATA_W-1:0] TEST_PAT    = 'h55,
  parameter int unsigned       TIMEOUT_CYC = 16
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 start,
  output logic                 busy,
  output logic                 done,
  output logic [CNT_W-1:0]     present_cnt,
  output logic [NUM_SLOTS-1:0] present_map,
  output logic [ADDR_W-1:0]    io_addr,
  output logic [DATA_W-1:0]    io_wdata,
  output logic                 io_wr,
  output logic                 io_rd,
  input  logic [DATA_W-1:0]    io_rdata,
  input  logic                 io_ready
);

  localparam logic [SLOT_W-1:0] LAST_SLOT = SLOT_W'(NUM_SLOTS - 1);

  probe_state_e      state_q, state_d;
  logic [SLOT_W-1:0] slot_q, slot_d;
  logic              slot_en;
  logic              clear_tally;
  logic              hit_en;
  logic              step;
  logic              timer_exp;
  logic              strobe_act;

  // Next-state logic
  always_comb begin
    state_d     = state_q;
    slot_d      = slot_q;
    clear_tally = 1'b0;
    hit_en      = 1'b0;
    step        = 1'b0;
    case (state_q)
      ST_IDLE: begin
        if (start) begin
          state_d     = ST_WRITE;
          slot_d      = '0;
          clear_tally = 1'b1;
        end
      end
      ST_WRITE: begin
        if (io_ready) begin
          state_d = ST_READ;
        end else if (timer_exp) begin
          step = 1'b1;
        end
      end
      ST_READ: begin
        if (io_ready || timer_exp) begin
          hit_en = io_ready && (io_rdata == TEST_PAT);
          step   = 1'b1;
        end
      end
      ST_FIN:  state_d = ST_IDLE;
      default: state_d = ST_IDLE;
    endcase
    if (step) begin
      if (slot_q == LAST_SLOT) begin
        state_d = ST_FIN;
      end else begin
        state_d = ST_WRITE;
        slot_d  = slot_q + 1'b1;
      end
    end
    slot_en = clear_tally || (step && (slot_q != LAST_SLOT));
  end

  // State registers
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
    end else begin
      state_q <= state_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      slot_q <= '0;
    end else if (slot_en) begin
      slot_q <= slot_d;
    end
  end

  assign io_wr      = (state_q == ST_WRITE);
  assign io_rd      = (state_q == ST_READ);
  assign strobe_act = io_wr || io_rd;
  assign io_wdata   = TEST_PAT;
  assign busy       = (state_q != ST_IDLE);
  assign done       = (state_q == ST_FIN);

  probe_slot_map #(
    .ADDR_W  (ADDR_W),
    .REG_OFF (REG_OFF)
  ) u_map (
    .slot_idx (slot_q),
    .reg_addr (io_addr)
  );

  probe_access_timer #(
    .TIMEOUT_CYC (TIMEOUT_CYC)
  ) u_timer (
    .clk     (clk),
    .rst_n   (rst_n),
    .active  (strobe_act),
    .ready   (io_ready),
    .expired (timer_exp)
  );

  probe_tally u_tally (
    .clk       (clk),
    .rst_n     (rst_n),
    .clear     (clear_tally),
    .hit_en    (hit_en),
    .hit_slot  (slot_q),
    .found_cnt (present_cnt),
    .found_map (present_map)
  );

endmodule

// File: rtl/scratch_probe_chk.sv
module scratch_probe_chk
  import scratch_probe_pkg::*;
#(
  parameter int unsigned ADDR_W      = 16,
  parameter int unsigned TIMEOUT_CYC = 16
) (
  input logic                 clk,
  input logic                 rst_n,
  input logic                 start,
  input logic                 busy,
  input logic                 done,
  input logic [CNT_W-1:0]     present_cnt,
  input logic [NUM_SLOTS-1:0] present_map,
  input logic [ADDR_W-1:0]    io_addr,
  input logic                 io_wr,
  input logic                 io_rd,
  input logic                 io_ready
);

  // Length of the current access so far, counted independently of the timer.
  logic              prev_act, prev_wr, prev_rdy;
  logic [ADDR_W-1:0] prev_addr;
  int unsigned       run_len;
  logic              same_acc;

  assign same_acc = prev_act && !prev_rdy && (io_addr == prev_addr) && (io_wr == prev_wr);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      prev_act  <= 1'b0;
      prev_wr   <= 1'b0;
      prev_rdy  <= 1'b0;
      prev_addr <= '0;
      run_len   <= 0;
    end else begin
      prev_act  <= io_wr || io_rd;
      prev_wr   <= io_wr;
      prev_rdy  <= io_ready;
      prev_addr <= io_addr;
      if (io_wr || io_rd) begin
        run_len <= same_acc ? run_len + 1 : 1;
      end else begin
        run_len <= 0;
      end
    end
  end

  // R9
  one_strobe_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(io_wr && io_rd));

  // R9
  idle_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> (!io_wr && !io_rd));

  // R2
  read_after_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(io_rd) |-> ($past(io_wr) && io_addr == $past(io_addr)));

  // R5
  strobe_window_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ((io_wr || io_rd) && same_acc) |-> (run_len < TIMEOUT_CYC));

  // R4
  tally_match_chk: assert property (@(posedge clk) disable iff (!rst_n)
    present_cnt == CNT_W'($countones(present_map)));

  // R6
  done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  // R6
  hold_result_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy && !start) |=> ($stable(present_cnt) && $stable(present_map)));

  // R10
  start_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (start && !busy) |=> (io_wr && present_cnt == '0 && present_map == '0));

endmodule

bind scratch_probe scratch_probe_chk #(
  .ADDR_W      (ADDR_W),
  .TIMEOUT_CYC (TIMEOUT_CYC)
) u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .start       (start),
  .busy        (busy),
  .done        (done),
  .present_cnt (present_cnt),
  .present_map (present_map),
  .io_addr     (io_addr),
  .io_wr       (io_wr),
  .io_rd       (io_rd),
  .io_ready    (io_ready)
);

// File: tb/scratch_probe_tb.sv
`timescale 1ns/1ps
module scratch_probe_tb;

  localparam int TMO = 8;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        start;
  logic        busy, done;
  logic [2:0]  present_cnt;
  logic [3:0]  present_map;
  logic [15:0] io_addr;
  logic [7:0]  io_wdata;
  logic        io_wr, io_rd;
  logic [7:0]  io_rdata;
  logic        io_ready;

  always #2.5 clk = ~clk;

  scratch_probe #(.TIMEOUT_CYC(TMO)) u_dut (
    .clk(clk), .rst_n(rst_n), .start(start), .busy(busy), .done(done),
    .present_cnt(present_cnt), .present_map(present_map),
    .io_addr(io_addr), .io_wdata(io_wdata), .io_wr(io_wr), .io_rd(io_rd),
    .io_rdata(io_rdata), .io_ready(io_ready)
  );

  // {good[23:20], faulty[19:16], noready[15:12], latency[11:8], exp_map[7:4], exp_cnt[2:0]}
  localparam logic [23:0] VECS [9] = '{
    24'hF000F4, 24'h000100, 24'h500252, 24'hF200D3, 24'h708373,
    24'hF007F4, 24'hF00800, 24'h906292, 24'hA004A2
  };

  int n_run = 0;
  int n_fail = 0;

  // Bus target model state
  logic [3:0]  m_good, m_faulty, m_noready;
  int          m_lat;
  logic [7:0]  scr [4];
  int          m_cnt;
  logic        p_act, p_wr;
  logic [15:0] p_addr;
  logic [24:0] log_q [16];
  int          log_n;
  int          done_hi;
  int          bad_strobe = 0;

  function automatic logic [15:0] win_addr(input int i);
    case (i)
      0: return 16'h03FF;
      1: return 16'h02FF;
      2: return 16'h03EF;
      default: return 16'h02EF;
    endcase
  endfunction

  function automatic logic [2:0] slot_of(input logic [15:0] a);
    case (a)
      16'h03FF: return 3'd0;
      16'h02FF: return 3'd1;
      16'h03EF: return 3'd2;
      16'h02EF: return 3'd3;
      default:  return 3'b100;
    endcase
  endfunction

  always @(negedge clk) begin
    logic       act;
    logic [2:0] s;
    if (!rst_n) begin
      io_ready = 1'b0;
      io_rdata = 8'h00;
      m_cnt    = 0;
      p_act    = 1'b0;
      p_wr     = 1'b0;
      p_addr   = 16'h0;
    end else begin
      io_ready = 1'b0;
      act = io_wr || io_rd;
      if (act && (!p_act || io_addr != p_addr || io_wr != p_wr)) begin
        m_cnt = 0;
        if (log_n < 16) log_q[log_n] = {io_wr, io_addr, io_wdata};
        log_n++;
      end
      if (act) begin
        s = slot_of(io_addr);
        if (!s[2] && !m_noready[s[1:0]]) begin
          if (m_cnt == m_lat) begin
            io_ready = 1'b1;
            if (io_wr && m_good[s[1:0]]) scr[s[1:0]] = io_wdata;
            if (io_rd) io_rdata = m_good[s[1:0]] ?
                         (m_faulty[s[1:0]] ? (scr[s[1:0]] ^ 8'h01) : scr[s[1:0]]) : 8'hFF;
          end else begin
            m_cnt++;
          end
        end
      end
      if ((act && !busy) || (io_wr && io_rd)) bad_strobe++;
      if (done) done_hi++;
      p_act  = act;
      p_addr = io_addr;
      p_wr   = io_wr;
    end
  end

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    n_run++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic load_model(input logic [23:0] v);
    m_good    = v[23:20];
    m_faulty  = v[19:16];
    m_noready = v[15:12];
    m_lat     = int'(v[11:8]);
    for (int i = 0; i < 4; i++) scr[i] = 8'h00;
    log_n   = 0;
    done_hi = 0;
  endtask

  task automatic run_probe(input logic [23:0] v, input bit poke);
    int   w;
    int   e;
    bit   seq_ok;
    logic [3:0] map_at_done;
    load_model(v);
    @(negedge clk); start = 1'b1;
    @(negedge clk); start = 1'b0;
    // R10: first write on the bus, tally cleared
    check(io_wr && io_addr == 16'h03FF, "R10 first write", {io_wr, io_addr}, {1'b1, 16'h03FF});
    check(present_map == 4'h0 && present_cnt == 3'd0, "R10 clear on start",
          {present_cnt, present_map}, 0);
    if (poke) begin
      repeat (3) @(negedge clk);
      start = 1'b1;
      @(negedge clk); start = 1'b0;
    end
    w = 0;
    while (!done && w < 400) begin
      @(negedge clk);
      w++;
    end
    map_at_done = present_map;
    check(present_map == v[7:4], "R3/R1 map", present_map, v[7:4]);
    check(present_cnt == v[2:0], "R4 count", present_cnt, v[2:0]);
    repeat (3) @(negedge clk);
    check(done_hi == 1, "R6 done width", done_hi, 1);
    check(!busy && present_map == map_at_done, "R6 hold", present_map, map_at_done);
    // R1 R2 R5: expected access sequence
    e = 0;
    seq_ok = 1'b1;
    for (int i = 0; i < 4; i++) begin
      if (e >= log_n || log_q[e] != {1'b1, win_addr(i), 8'h55}) seq_ok = 1'b0;
      e++;
      if (!v[12 + i] && int'(v[11:8]) <= TMO - 1) begin
        if (e >= log_n || log_q[e][24:8] != {1'b0, win_addr(i)}) seq_ok = 1'b0;
        e++;
      end
    end
    check(seq_ok && log_n == e, "R1/R2/R5/R7 access sequence", log_n, e);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_run++;
    n_fail++;
    $display("FAIL watchdog expired actual=running expected=finished");
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    rst_n = 1'b0;
    start = 1'b0;
    m_good = 4'h0; m_faulty = 4'h0; m_noready = 4'h0; m_lat = 0;
    log_n = 0; done_hi = 0;
    for (int i = 0; i < 4; i++) scr[i] = 8'h00;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R8: reset state
    check(!busy && !done && present_cnt == 0 && present_map == 0 && !io_wr && !io_rd,
          "R8 reset state", {busy, done, present_cnt, present_map}, 0);

    // Vector walk: R1 R2 R3 R4 R5 R6 R10
    for (int v = 0; v < 9; v++) begin
      run_probe(VECS[v], 1'b0);
    end

    // R7: start pulse during a survey is ignored
    run_probe(24'h500252, 1'b1);

    // R6: result held over a long idle stretch
    repeat (20) @(negedge clk);
    check(present_map == 4'h5 && present_cnt == 3'd2, "R6 long hold", present_map, 4'h5);

    // R8: asynchronous reset in the middle of a survey
    load_model(24'hF002F4);
    @(negedge clk); start = 1'b1;
    @(negedge clk); start = 1'b0;
    repeat (9) @(negedge clk);
    #1 rst_n = 1'b0;
    #0.5;
    check(!busy && !io_wr && !io_rd && present_cnt == 0 && present_map == 0,
          "R8 mid-run reset", {busy, io_wr, io_rd, present_map}, 0);
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    check(!busy && !done && present_map == 0, "R8 after release", {busy, present_map}, 0);

    // Survey still works after reset
    run_probe(24'hF000F4, 1'b0);

    // R9: strobe discipline over the whole run
    check(bad_strobe == 0, "R9 strobe discipline", bad_strobe, 0);

    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

endmodule